// File: doc/BRIEF.md
# Channel Unit Assignment Controller

This block hands shared execution units to the channels that ask for them. Each channel names one unit at a time with a one-hot select and holds a request line high. A unit that is free when the request is sampled is granted to that channel. The grant stays set until the channel pulses a release bit for that unit, and the unit then goes back to the free pool.

A channel that needs two units asks for them one after the other, primary first and secondary second. The primary is granted as soon as it is free, even if the secondary is still taken. Once a channel holds two units, it may switch on snoop-in and snoop-out for its secondary unit, and the block reports that state back to the channel. A release that covers both units ends the pairing and clears the snoop state.

When several channels contend for the same free unit in one cycle, the lowest-numbered channel wins.

Top module: `unit_assign`

## Requirements
- R1: After reset, every grant bit, every snoop status bit and every busy bit is 0.
- R2: A request from channel c with a one-hot select naming a free unit u sets grant bit c*NU+u at the next clock edge. The busy bit u is set at the same edge.
- R3: A request for a unit that is busy is not granted while it is busy. The unit becomes free at the edge that samples its release. A request still held is granted at the edge after that.
- R4: A grant stays set, cycle after cycle, until the owning channel asserts release bit c*NU+u. The grant clears at the edge that samples that release.
- R5: When several channels request the same free unit in the same cycle, only the lowest-numbered of them is granted.
- R6: A channel that holds one unit may request a second unit. A primary request is granted without waiting for any other unit to become free.
- R7: A channel holds at most two units. A request from a channel that already holds two units is ignored.
- R8: Snoop status bits 2c (snoop-in) and 2c+1 (snoop-out) follow snoop enable bits 2c and 2c+1 one edge later. This happens only while channel c holds exactly two units and releases none of them. Otherwise the status bits are 0.
- R9: A release bit for a unit that the channel does not hold has no effect on any grant.
- R10: No unit is ever granted to two channels at once. Busy bit u is 1 exactly when some channel holds unit u.
- R11: A request whose select is not one-hot (zero bits or several bits set) is ignored.
- R12: A release covering both units of a pair clears both grants and the snoop status at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NCH | Per-channel request line, held until granted |
| sel_i | input | NCH*NU | Per-channel one-hot unit select, bit c*NU+u names unit u |
| rel_i | input | NCH*NU | Per-channel release pulse, bit c*NU+u frees unit u |
| snp_en_i | input | 2*NCH | Per-channel snoop enables, bit 2c snoop-in, bit 2c+1 snoop-out |
| gnt_o | output | NCH*NU | Grant held by channel c for unit u at bit c*NU+u |
| snp_sta_o | output | 2*NCH | Per-channel snoop status, same bit layout as snp_en_i |
| busy_o | output | NU | Unit taken by some channel |

## Verification
Grant and busy bits change one edge after the request is sampled. A release frees its unit at the edge that samples it. A requester that was blocked gets the unit one edge later again, and snoop status trails its enable by one edge. The bench changes inputs just after a falling edge and reads outputs at the next falling edge, so each check sees the result of exactly one rising edge. The release-then-grant case is stepped edge by edge, with a check at each step that the unit is not handed out early.

// File: rtl/unit_assign.sv
module unit_assign #(
  parameter int NCH = 4,
  parameter int NU  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      req_i,
  input  logic [NCH*NU-1:0]   sel_i,
  input  logic [NCH*NU-1:0]   rel_i,
  input  logic [2*NCH-1:0]    snp_en_i,
  output logic [NCH*NU-1:0]   gnt_o,
  output logic [2*NCH-1:0]    snp_sta_o,
  output logic [NU-1:0]       busy_o
);
  localparam int NB = NCH * NU;

  logic [NB-1:0]    held_q, win;
  logic [NCH-1:0]   ok;
  logic [2*NCH-1:0] snp_q, snp_d;
  logic [NU-1:0]    busy;
  logic             taken;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NU-1:0] own, pick, drop;
    logic          full;
    assign own  = held_q[c*NU +: NU];
    assign pick = sel_i[c*NU +: NU];
    assign drop = rel_i[c*NU +: NU];
    assign full = ($countones(own) == 2);
    assign ok[c] = req_i[c] && $onehot(pick) && ($countones(own) < 2);
    assign snp_d[2*c +: 2] = (full && (drop & own) == '0) ? snp_en_i[2*c +: 2] : 2'b00;
  end

  always_comb begin
    busy = '0;
    for (int c = 0; c < NCH; c++) busy = busy | held_q[c*NU +: NU];
  end

  always_comb begin
    win   = '0;
    taken = 1'b0;
    for (int u = 0; u < NU; u++) begin
      taken = busy[u];
      for (int c = 0; c < NCH; c++) begin
        if (!taken && ok[c] && sel_i[c*NU+u]) begin
          win[c*NU+u] = 1'b1;
          taken = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      snp_q  <= '0;
    end else begin
      held_q <= (held_q & ~rel_i) | win;
      snp_q  <= snp_d;
    end
  end

  assign gnt_o     = held_q;
  assign snp_sta_o = snp_q;
  assign busy_o    = busy;
endmodule

// File: rtl/unit_assign_chk.sv
module unit_assign_chk #(
  parameter int NCH = 4,
  parameter int NU  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    req_i,
  input logic [NCH*NU-1:0] sel_i,
  input logic [NCH*NU-1:0] rel_i,
  input logic [NCH*NU-1:0] gnt_o,
  input logic [2*NCH-1:0]  snp_sta_o,
  input logic [NU-1:0]     busy_o
);
  for (genvar u = 0; u < NU; u++) begin : g_u
    logic [NCH-1:0] col;
    always_comb for (int c = 0; c < NCH; c++) col[c] = gnt_o[c*NU+u];

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col)); // R10
    AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o[u] == (col != '0)); // R10

    for (genvar c = 0; c < NCH; c++) begin : g_c
      AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_o[c*NU+u]) |-> $past(req_i[c] && sel_i[c*NU+u])); // R2
      AST_GRANT_WAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_o[c*NU+u]) |-> !$past(busy_o[u])); // R3
      AST_HOLD_TILL_REL: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_o[c*NU+u] && !rel_i[c*NU+u] |=> gnt_o[c*NU+u]); // R4
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_cap
    AST_TWO_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gnt_o[c*NU +: NU]) <= 2); // R7
    AST_SNOOP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      snp_sta_o[2*c +: 2] != 2'b00 |->
        $past($countones(gnt_o[c*NU +: NU]) == 2 &&
              (rel_i[c*NU +: NU] & gnt_o[c*NU +: NU]) == '0)); // R8
  end
endmodule

bind unit_assign unit_assign_chk #(.NCH(NCH), .NU(NU)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .sel_i(sel_i), .rel_i(rel_i),
  .gnt_o(gnt_o), .snp_sta_o(snp_sta_o), .busy_o(busy_o)
);

// File: tb/test_unit_assign.sv
module test_unit_assign;
  localparam int NCH = 4;
  localparam int NU  = 4;
  localparam int NB  = NCH * NU;
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0]   req = '0;
  logic [NB-1:0]    sel = '0, rel = '0;
  logic [2*NCH-1:0] snp = '0;
  logic [NB-1:0]    gnt;
  logic [2*NCH-1:0] sta;
  logic [NU-1:0]    busy;
  int total = 0, bad = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  unit_assign #(.NCH(NCH), .NU(NU)) i_unit_assign (
    .clk(clk), .rst_n(rst_n), .req_i(req), .sel_i(sel), .rel_i(rel),
    .snp_en_i(snp), .gnt_o(gnt), .snp_sta_o(sta), .busy_o(busy));

  function automatic logic [31:0] gb(int c, int u);
    return 32'(1) << (c*NU + u);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic ask(int c, int u);
    req[c] = 1'b1;
    sel[c*NU +: NU] = NU'(1) << u;
  endtask

  task automatic quiet(int c);
    req[c] = 1'b0;
    sel[c*NU +: NU] = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R1 gnt", 32'(gnt), 0);
    chk("R1 sta", 32'(sta), 0);
    chk("R1 busy", 32'(busy), 0);
    rst_n = 1'b1;
    tick();

    // R5 R2 R10 R4 sweep: every channel subset contending for every unit
    for (int u = 0; u < NU; u++) begin
      for (int m = 1; m < (1 << NCH); m++) begin
        int low;
        low = -1;
        for (int c = NCH-1; c >= 0; c--) if (m[c]) low = c;
        for (int c = 0; c < NCH; c++) if (m[c]) ask(c, u);
        tick();
        chk("R5 lowest wins", 32'(gnt), gb(low, u));
        chk("R10 busy", 32'(busy), 32'(1) << u);
        tick();
        chk("R4 held, R3 losers wait", 32'(gnt), gb(low, u));
        for (int c = 0; c < NCH; c++) quiet(c);
        rel[low*NU + u] = 1'b1;
        tick();
        rel = '0;
        chk("R4 released", 32'(gnt), 0);
      end
    end

    // R11: select not one-hot
    req[2] = 1'b1; sel[2*NU +: NU] = 4'b0011;
    tick();
    chk("R11 two bits", 32'(gnt), 0);
    sel[2*NU +: NU] = 4'b0000;
    tick();
    chk("R11 zero bits", 32'(gnt), 0);
    quiet(2);

    // R3 edge timing: ch1 holds u2, ch0 waits
    ask(1, 2); tick();
    chk("R2 grant", 32'(gnt), gb(1, 2));
    quiet(1); ask(0, 2); tick();
    chk("R3 blocked", 32'(gnt), gb(1, 2));
    rel[1*NU+2] = 1'b1; tick(); rel = '0;
    chk("R3 freed not yet granted", 32'(gnt), 0);
    tick();
    chk("R3 granted after free", 32'(gnt), gb(0, 2));
    quiet(0);
    rel[0*NU+2] = 1'b1; tick(); rel = '0;

    // R6: ch0 holds u0, ch2 holds u1; ch1 primary u3 granted though its secondary u1 busy
    ask(0, 0); ask(2, 1); tick(); quiet(0); quiet(2);
    ask(1, 3); tick(); quiet(1);
    chk("R6 primary alone", 32'(gnt), gb(0,0) | gb(2,1) | gb(1,3));
    snp[2*1 +: 2] = 2'b11; tick();
    chk("R8 one unit no snoop", 32'(sta), 0);
    ask(1, 1); tick();
    chk("R6 secondary waits", 32'(gnt), gb(0,0) | gb(2,1) | gb(1,3));
    rel[2*NU+1] = 1'b1; tick(); rel = '0;
    tick(); quiet(1);
    chk("R6 secondary granted", 32'(gnt), gb(0,0) | gb(1,1) | gb(1,3));
    snp[2*1 +: 2] = 2'b01; tick();
    chk("R8 snoop-in", 32'(sta), 32'(2'b01) << 2);
    snp[2*1 +: 2] = 2'b10; tick();
    chk("R8 snoop-out", 32'(sta), 32'(2'b10) << 2);

    // R7: third request ignored
    ask(1, 2); tick(); quiet(1);
    chk("R7 third ignored", 32'(gnt), gb(0,0) | gb(1,1) | gb(1,3));
    chk("R7 busy", 32'(busy), 32'b1011);

    // R9: ch0 releases u3 (not its own) and u2 (nobody's)
    rel[0*NU+3] = 1'b1; rel[0*NU+2] = 1'b1; tick(); rel = '0;
    chk("R9 foreign release", 32'(gnt), gb(0,0) | gb(1,1) | gb(1,3));

    // R12: pair release clears grants and snoop at once
    snp[2*1 +: 2] = 2'b11; tick();
    chk("R8 both", 32'(sta), 32'(2'b11) << 2);
    rel[1*NU+1] = 1'b1; rel[1*NU+3] = 1'b1; tick(); rel = '0;
    chk("R12 grants", 32'(gnt), gb(0,0));
    chk("R12 snoop", 32'(sta), 0);
    snp = '0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule